// File: doc/BRIEF.md
# Sticky Interrupt Flag Register

This block keeps the interrupt flags of a non-volatile memory controller. The controller core reports events as single-cycle pulses, and each pulse sets a flag that stays at 1 until something clears it. Software reads the flags, and clears most of them, through a plain register bus with read, write, address, write data and read data pins. The flag word is 16 bits wide and sits at byte offset 0x10.

There are three kinds of flag. Eight general event flags clear when software writes a 1 to their bit position. The two ECC flags cannot be written from the bus. They clear only when software reads a separate ECC error register, which the block sees as a pulse on `ecc_log_read`. One status bit follows the emulated-EEPROM write in progress: it drops to 0 when a write starts and rises to 1 when that write completes. An event that arrives in the same cycle as a clear always leaves its flag set, so no event is lost.

A registered interrupt line is the OR of all flags masked by a 16-bit enable input.

Top module: `nvm_flag_reg`

## Requirements
- R1: While `rst_n` is low, and after its release, every flag reads 0 and `irq_out` is 0.
- R2: A pulse on `event_in[i]`, for i in 0..3 or 6..9, sets flag bit i at the next clock edge, and the flag stays 1 until it is cleared. The bit meanings are: 0 command done, 1 address error, 2 programming error, 3 lock error, 6 memory error, 7 suspended write or erase, 8 active sector full, 9 sector overflow.
- R3: A bus write to address 0x10 clears each of bits 0..3 and 6..9 whose write-data bit is 1. A write-data bit of 0, or a write to any other address, leaves the flag unchanged.
- R4: When an event pulse and a write-one clear hit the same flag in the same cycle, the flag is 1 afterwards.
- R5: Flag bits 4 (ECC single error) and 5 (ECC dual error) are set by `event_in[4]` and `event_in[5]`. Bus writes do not change them. They clear on an `ecc_log_read` pulse, and an event in the same cycle as that pulse wins.
- R6: Flag bit 10 (emulated-EEPROM write completed) goes to 0 on a `ee_wr_start` pulse and to 1 on a `ee_wr_done` pulse. If both pulses arrive in the same cycle, the bit becomes 1. Bus writes do not change it.
- R7: Bits 11..15 always read 0, whatever is written to them.
- R8: `reg_rdata` shows the flag word in the same cycle that `reg_rd` is high with `reg_addr` equal to 0x10. At all other times it is 0.
- R9: `irq_out` is registered. After each clock edge it equals the OR of (flags AND `irq_en`), taken from the values before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Bus read strobe |
| reg_wr | input | 1 | Bus write strobe |
| reg_addr | input | 8 | Bus byte address |
| reg_wdata | input | 16 | Bus write data |
| reg_rdata | output | 16 | Bus read data |
| event_in | input | 10 | Event pulses from the controller core, one per flag bit 0..9 |
| ecc_log_read | input | 1 | Pulse when the separate ECC error register is read |
| ee_wr_start | input | 1 | Pulse when an emulated-EEPROM write becomes pending |
| ee_wr_done | input | 1 | Pulse when that write has completed |
| irq_en | input | 16 | Interrupt enable mask, one bit per flag bit |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The assertions assume that the event, start, done and ECC-read inputs are single-cycle pulses that are sampled on clock edges. They also assume that bus strobes change only between edges and that reset is asserted for at least one edge before any check counts. The bench drives every input on the falling edge and holds each pulse for exactly one cycle. It performs each bus read in an idle cycle, so the inputs always stay within these assumptions. The bench also makes events and clears collide deliberately, so the set-wins cases are exercised.

// File: rtl/nvm_flag_pkg.sv
package nvm_flag_pkg;

  localparam int FLAG_W = 16;
  localparam int EVT_W  = 10;

  typedef enum logic [1:0] {
    FK_W1C    = 2'd0,
    FK_SIDECLR = 2'd1,
    FK_STATUS = 2'd2,
    FK_NONE   = 2'd3
  } flag_kind_e;

  localparam int BIT_ECC_SINGLE = 4;
  localparam int BIT_ECC_DUAL   = 5;
  localparam int BIT_EE_WRDONE  = 10;

  function automatic flag_kind_e kind_of(input int idx);
    if (idx == BIT_ECC_SINGLE || idx == BIT_ECC_DUAL) return FK_SIDECLR;
    if (idx == BIT_EE_WRDONE) return FK_STATUS;
    if (idx < EVT_W) return FK_W1C;
    return FK_NONE;
  endfunction

endpackage

// File: rtl/nvm_flag_cell.sv
module nvm_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_r;

  always_ff @(posedge clk) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= set_i | (q_r & ~clr_i);
  end

  assign q_o = q_r;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o) else $error("set pulse lost");                         // R4
  AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o) else $error("flag dropped without clear");   // R2

endmodule

// File: rtl/nvm_flag_bus.sv
module nvm_flag_bus #(
  parameter int               ADDR_W    = 8,
  parameter int               DATA_W    = 16,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h10
) (
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] flags_i,
  output logic [DATA_W-1:0] w1c_mask_o,
  output logic [DATA_W-1:0] reg_rdata
);

  logic hit;

  always_comb begin
    hit        = (reg_addr == FLAG_ADDR);
    w1c_mask_o = (reg_wr && hit) ? reg_wdata : '0;
    reg_rdata  = (reg_rd && hit) ? flags_i : '0;
  end

endmodule

// File: rtl/nvm_flag_irq.sv
module nvm_flag_irq #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] flags_i,
  input  logic [DATA_W-1:0] enable_i,
  output logic              irq_o
);

  logic irq_r;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_r <= 1'b0;
    else        irq_r <= |(flags_i & enable_i);
  end

  assign irq_o = irq_r;

endmodule

// File: rtl/nvm_flag_reg.sv
module nvm_flag_reg #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_rd,
  input  logic                           reg_wr,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [nvm_flag_pkg::FLAG_W-1:0] reg_wdata,
  output logic [nvm_flag_pkg::FLAG_W-1:0] reg_rdata,
  input  logic [nvm_flag_pkg::EVT_W-1:0]  event_in,
  input  logic                           ecc_log_read,
  input  logic                           ee_wr_start,
  input  logic                           ee_wr_done,
  input  logic [nvm_flag_pkg::FLAG_W-1:0] irq_en,
  output logic                           irq_out
);
  import nvm_flag_pkg::*;

  localparam int W = FLAG_W;

  logic [W-1:0] flags;
  logic [W-1:0] w1c_mask;

  nvm_flag_bus #(.ADDR_W(ADDR_W), .DATA_W(W), .FLAG_ADDR(FLAG_ADDR)) u_bus (
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .flags_i    (flags),
    .w1c_mask_o (w1c_mask),
    .reg_rdata  (reg_rdata)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (kind_of(i) == FK_NONE) begin : g_none
      assign flags[i] = 1'b0;
    end else begin : g_live
      logic set_s, clr_s;
      if (kind_of(i) == FK_W1C) begin : g_w1c
        assign set_s = event_in[i];
        assign clr_s = w1c_mask[i];
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
          (w1c_mask[i] && !event_in[i]) |=> !flags[i])
          else $error("write-one clear failed");                       // R3
      end else if (kind_of(i) == FK_SIDECLR) begin : g_ecc
        assign set_s = event_in[i];
        assign clr_s = ecc_log_read;
        AST_ECC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
          (flags[i] && !ecc_log_read) |=> flags[i])
          else $error("ECC flag changed without log read");            // R5
      end else begin : g_status
        assign set_s = ee_wr_done;
        assign clr_s = ee_wr_start;
        AST_WRC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
          (ee_wr_start && !ee_wr_done) |=> !flags[i])
          else $error("write-complete bit not cleared on start");      // R6
      end
      nvm_flag_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_s),
        .clr_i (clr_s),
        .q_o   (flags[i])
      );
    end
  end

  nvm_flag_irq #(.DATA_W(W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .flags_i  (flags),
    .enable_i (irq_en),
    .irq_o    (irq_out)
  );

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_comb begin
    AST_UNUSED_ZERO: assert (reg_rdata[W-1:BIT_EE_WRDONE+1] == '0)
      else $error("unimplemented bits non-zero");                      // R7
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> (reg_rdata == '0)) else $error("read data without read"); // R8

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |=> (irq_out == |($past(flags) & $past(irq_en))))
    else $error("interrupt does not follow masked flags");             // R9

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (flags == '0 && !irq_out)) else $error("reset state wrong"); // R1

endmodule

// File: tb/nvm_flag_reg_test.sv
module nvm_flag_reg_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [9:0]  event_in = '0;
  logic        ecc_log_read = 1'b0, ee_wr_start = 1'b0, ee_wr_done = 1'b0;
  logic [15:0] irq_en = '0;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  nvm_flag_reg uut (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .event_in(event_in), .ecc_log_read(ecc_log_read),
    .ee_wr_start(ee_wr_start), .ee_wr_done(ee_wr_done),
    .irq_en(irq_en), .irq_out(irq_out)
  );

  typedef struct packed {
    logic [9:0]  ev;
    logic        wr;
    logic [15:0] wd;
    logic        ecc;
    logic        st;
    logic        dn;
    logic [15:0] en;
    logic [15:0] exp;
    logic        irq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{10'h001, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0001, 1'b0}, // R2
    '{10'h00E, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0001, 16'h000F, 1'b1}, // R2 R9
    '{10'h000, 1'b1, 16'h0003, 1'b0, 1'b0, 1'b0, 16'h0001, 16'h000C, 1'b0}, // R3
    '{10'h3C0, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0200, 16'h03CC, 1'b1}, // R2 R3
    '{10'h030, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h03FC, 1'b0}, // R5
    '{10'h000, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 16'h0010, 16'h0030, 1'b1}, // R3 R5
    '{10'h000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0010, 16'h0000, 1'b0}, // R5
    '{10'h000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0400, 16'h0400, 1'b1}, // R6
    '{10'h000, 1'b1, 16'h0400, 1'b0, 1'b0, 1'b0, 16'h0400, 16'h0400, 1'b1}, // R6
    '{10'h000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0400, 16'h0000, 1'b0}, // R6
    '{10'h004, 1'b1, 16'h0004, 1'b0, 1'b0, 1'b0, 16'hF800, 16'h0004, 1'b0}, // R4
    '{10'h010, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0010, 16'h0014, 1'b1}, // R5
    '{10'h000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h0000, 16'h0414, 1'b0}  // R6
  };

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_rd = 0; reg_wr = 0; event_in = '0; ecc_log_read = 0;
    ee_wr_start = 0; ee_wr_done = 0;
  endtask

  task automatic read_flags(input string req, input logic [15:0] exp);
    @(negedge clk);
    idle();
    reg_rd = 1; reg_addr = 8'h10;
    #1 check16(req, reg_rdata, exp);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    idle();
    reg_wr = 1; reg_addr = a; reg_wdata = d;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: state during reset
    #1 check16("R1 rst", {15'd0, irq_out}, 16'h0);
    reg_rd = 1; reg_addr = 8'h10;
    #1 check16("R1 rst flags", reg_rdata, 16'h0);
    @(negedge clk);
    rst_n = 1;
    read_flags("R1 after release", 16'h0000);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      idle();
      event_in = TBL[k].ev; reg_wr = TBL[k].wr; reg_addr = 8'h10;
      reg_wdata = TBL[k].wd; ecc_log_read = TBL[k].ecc;
      ee_wr_start = TBL[k].st; ee_wr_done = TBL[k].dn; irq_en = TBL[k].en;
      read_flags($sformatf("R2-row%0d flags", k), TBL[k].exp);
      @(negedge clk);
      idle();
      #1 check16($sformatf("R9 row%0d irq", k), {15'd0, irq_out}, {15'd0, TBL[k].irq});
    end

    // R3: write to another address has no effect (flags 0x0414)
    bus_write(8'h14, 16'hFFFF);
    read_flags("R3 wrong address", 16'h0414);
    // R7: writes to unused bits, and ECC/status bits, ignored
    bus_write(8'h10, 16'hF830);
    read_flags("R7 unused bits", 16'h0414);
    // R8: no read strobe gives zero data
    @(negedge clk);
    idle(); reg_addr = 8'h10;
    #1 check16("R8 idle read data", reg_rdata, 16'h0000);
    reg_rd = 1; reg_addr = 8'h11;
    #1 check16("R8 other address", reg_rdata, 16'h0000);
    // R9: enable mask change reflected one edge later
    @(negedge clk);
    idle(); irq_en = 16'h0004;
    @(negedge clk);
    #1 check16("R9 mask enable", {15'd0, irq_out}, 16'h0001);
    // R1: reset mid-run
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    #1 check16("R1 mid reset irq", {15'd0, irq_out}, 16'h0);
    rst_n = 1;
    read_flags("R1 mid reset flags", 16'h0000);

    @(negedge clk);
    idle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule